// File: doc/BRIEF.md
# Dynamic Memory Access Phase Sequencer

This block is the timing controller for one access to a one-transistor dynamic memory array. The array has 2^ADDR_W word lines, and each word line selects a full column of DATA_W cells. A requester raises `req` with an address, a write flag and a write word. The sequencer then runs a fixed series of digital strobes in a fixed order. The series covers:
- bit-line precharge;
- decoder precharge, address enable and discharge;
- the word-line pulse, with one selected word line and a dummy word line;
- a slow and then a fast latch pull-down;
- a bit-line equalize, during which the dummy reference is stored again.

At the end of the series the block returns the sensed word on `rd_data` and pulses `ack`.

Reads and writes use the same series of strobes. During a write, `wr_drv` is high for the whole sense window and `wr_data` carries the word, so the array's bit lines take their value from the data and not from the cell. Every phase lasts a parameter count of clocks. At 100 MHz the default counts give data after about 150 ns and a cycle of 250 ns. Only one strobe group changes on any one clock.

Top module: `dram_phase_seq`

## Requirements
- R1: Out of reset the block is idle. `bl_pre` and `dec_pre` are 1. `addr_en`, `dec_dis`, `wl_pulse`, `wl`, `dwl`, `sense_slow`, `sense_fast`, `eq`, `wr_drv`, `ack` and `busy` are 0.
- R2: When `req` is high in idle, the next clock starts a cycle. The first change is `bl_pre` falling. `busy` is then 1 until the cycle ends.
- R3: In a cycle, `dec_pre` falls T_GAP clocks after `bl_pre`. Then `addr_en` rises, then `dec_dis` rises, then `wl_pulse` rises, each T_GAP clocks after the one before. `dec_pre` is never 1 while any of these three is 1.
- R4: `wl` is one-hot at bit `addr` for exactly as long as `wl_pulse` is 1, which is T_WORD+T_SLOW+T_FAST clocks. At all other times `wl` is zero.
- R5: `dwl` rises on the same clock as `wl_pulse`, and always in the half opposite to the addressed row. If address bit ADDR_W-1 is 0, `dwl`=2'b10 (upper-half dummy). Otherwise `dwl`=2'b01.
- R6: `sense_slow` rises T_WORD clocks after `wl_pulse`. `sense_fast` rises T_SLOW clocks after `sense_slow`, while `sense_slow` stays 1.
- R7: After T_FAST clocks of fast sensing, `wl_pulse` falls first. The pull-downs fall T_GAP later. `eq` rises T_GAP after that. `dwl` falls T_EQ clocks into `eq`. `eq` falls T_GAP after `dwl`.
- R8: After `eq` falls, the block returns to idle in this order, one step every T_GAP clocks: `dec_dis` falls, then `addr_en` falls, then `dec_pre` rises, then `bl_pre` rises together with a one-clock `ack`. `busy` is 0 on the clock after `ack`.
- R9: A write shows the same strobe timing as a read. `wr_drv` is 1 exactly while `sense_slow` is 1, and only on writes. While `wr_drv` is 1, `wr_data` equals the request's word.
- R10: `rd_data` changes only with `ack`. It then holds the value `sa_data` had on the last clock of fast sensing, so a write returns the word written. It keeps that value until the next `ack`.
- R11: Changes to `addr`, `wr` and `wdata` during a cycle have no effect on it. A `req` held high through `ack` is not taken until one idle clock has passed, after which it starts the next cycle.
- R12: Apart from the word and dummy lines rising together, and the two pull-downs falling together, no two of `bl_pre`, `dec_pre`, `addr_en`, `dec_dis`, `wl_pulse`, `sense_slow` and `eq` change on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until `ack` |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word-line address |
| wdata | input | DATA_W | Word to write |
| sa_data | input | DATA_W | Latched sense-amplifier outputs |
| ack | output | 1 | One-clock end-of-cycle pulse |
| busy | output | 1 | A cycle is in progress |
| rd_data | output | DATA_W | Word sensed in the last cycle |
| bl_pre | output | 1 | Bit-line precharge |
| dec_pre | output | 1 | Decoder precharge |
| addr_en | output | 1 | Decoder address enable |
| dec_dis | output | 1 | Decoder clamp-gate discharge |
| wl_pulse | output | 1 | Shared word-line drive pulse |
| wl | output | 2**ADDR_W | One-hot word-line select |
| dwl | output | 2 | Dummy word lines, bit 1 = upper half |
| sense_slow | output | 1 | Slow latch pull-down |
| sense_fast | output | 1 | Fast latch pull-down |
| eq | output | 1 | Bit-line equalize |
| wr_drv | output | 1 | Write-data bit-line drive enable |
| wr_data | output | DATA_W | Registered write word |

## Verification
Every one of the 128 rows is first written with a distinct arithmetic word and then read back in reverse order. This shows that each row gets its own one-hot line and the correct opposite-half dummy, and that read data comes from the addressed row and not a neighbour. During every cycle the bench flips `addr`, `wr` and `wdata` partway through, which separates a design that latches its request from one that follows its inputs. Some requests are kept high through `ack`. This separates a sequencer that rests one idle clock from one that restarts straight away. Each strobe is compared on every clock against windows computed from the phase counts, so a phase out of order or a length that is off by one shows up at the clock where it happens.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [4:0] {
    ST_IDLE       = 5'd0,
    ST_BL_REL     = 5'd1,
    ST_DEC_REL    = 5'd2,
    ST_ADDR_EN    = 5'd3,
    ST_DEC_DIS    = 5'd4,
    ST_WORD       = 5'd5,
    ST_SENSE_SLOW = 5'd6,
    ST_SENSE_FAST = 5'd7,
    ST_WORD_REL   = 5'd8,
    ST_SENSE_REL  = 5'd9,
    ST_EQ_ON      = 5'd10,
    ST_DUMMY_REL  = 5'd11,
    ST_EQ_REL     = 5'd12,
    ST_DIS_REL    = 5'd13,
    ST_ADDR_REL   = 5'd14,
    ST_DEC_PRE    = 5'd15,
    ST_DONE       = 5'd16
  } phase_e;

  typedef struct packed {
    logic bl_pre;
    logic dec_pre;
    logic addr_en;
    logic dec_dis;
    logic word;
    logic dummy;
    logic slow;
    logic fast;
    logic eq;
    logic wdrv;
    logic ack;
    logic busy;
  } strobe_t;

  // Strobe levels held during each phase; ordering of phases sets ordering of edges.
  function automatic strobe_t strobes_of(phase_e p, logic is_wr);
    strobe_t s;
    s.bl_pre  = (p == ST_IDLE) || (p == ST_DONE);
    s.dec_pre = (p == ST_IDLE) || (p == ST_BL_REL) || (p == ST_DEC_PRE) || (p == ST_DONE);
    s.addr_en = (p >= ST_ADDR_EN) && (p <= ST_DIS_REL);
    s.dec_dis = (p >= ST_DEC_DIS) && (p <= ST_EQ_REL);
    s.word    = (p >= ST_WORD) && (p <= ST_SENSE_FAST);
    s.dummy   = (p >= ST_WORD) && (p <= ST_EQ_ON);
    s.slow    = (p >= ST_SENSE_SLOW) && (p <= ST_WORD_REL);
    s.fast    = (p >= ST_SENSE_FAST) && (p <= ST_WORD_REL);
    s.eq      = (p >= ST_EQ_ON) && (p <= ST_DUMMY_REL);
    s.wdrv    = is_wr && s.slow;
    s.ack     = (p == ST_DONE);
    s.busy    = (p != ST_IDLE);
    return s;
  endfunction

endpackage

// File: rtl/dps_fsm.sv
module dps_fsm
  import dps_pkg::*;
#(
  parameter int unsigned T_GAP  = 1,
  parameter int unsigned T_WORD = 4,
  parameter int unsigned T_SLOW = 3,
  parameter int unsigned T_FAST = 3,
  parameter int unsigned T_EQ   = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    is_wr,
  output strobe_t strb_d,
  output strobe_t strb_q,
  output logic    accept,
  output logic    capture,
  output logic    finish
);

  localparam int unsigned T_M1  = (T_GAP > T_WORD) ? T_GAP : T_WORD;
  localparam int unsigned T_M2  = (T_SLOW > T_FAST) ? T_SLOW : T_FAST;
  localparam int unsigned T_M3  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int unsigned T_MAX = (T_M3 > T_EQ) ? T_M3 : T_EQ;
  localparam int unsigned CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic [4:0]       ph_inc;

  // Final count value of the phase currently held.
  always_comb begin
    case (ph_q)
      ST_WORD:       last = CNT_W'(T_WORD - 1);
      ST_SENSE_SLOW: last = CNT_W'(T_SLOW - 1);
      ST_SENSE_FAST: last = CNT_W'(T_FAST - 1);
      ST_EQ_ON:      last = CNT_W'(T_EQ - 1);
      ST_IDLE,
      ST_DONE:       last = '0;
      default:       last = CNT_W'(T_GAP - 1);
    endcase
  end

  assign ph_inc = ph_q + 5'd1;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == ST_IDLE) begin
      if (req) begin
        ph_d  = ST_BL_REL;
        cnt_d = '0;
      end
    end else if (cnt_q == last) begin
      cnt_d = '0;
      ph_d  = (ph_q == ST_DONE) ? ST_IDLE : phase_e'(ph_inc);
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign accept  = (ph_q == ST_IDLE) && req;
  assign capture = (ph_q == ST_SENSE_FAST) && (cnt_q == last);
  assign finish  = (ph_d == ST_DONE) && (ph_q != ST_DONE);
  assign strb_d  = strobes_of(ph_d, is_wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= ST_IDLE;
      cnt_q  <= '0;
      strb_q <= strobes_of(ST_IDLE, 1'b0);
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      strb_q <= strb_d;
    end
  end

endmodule

// File: rtl/dps_row_sel.sv
module dps_row_sel #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 word_d,
  input  logic                 dummy_d,
  input  logic [ADDR_W-1:0]    row,
  output logic [(1<<ADDR_W)-1:0] wl,
  output logic [1:0]           dwl
);

  localparam int unsigned ROWS = 1 << ADDR_W;

  logic [ROWS-1:0] sel;
  logic [1:0]      dsel;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign sel[g] = (row == ADDR_W'(g));
  end

  // Dummy line on the half that does not hold the addressed row.
  for (genvar h = 0; h < 2; h++) begin : g_dummy
    assign dsel[h] = (row[ADDR_W-1] != 1'(h));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wl  <= '0;
      dwl <= '0;
    end else begin
      wl  <= word_d  ? sel  : '0;
      dwl <= dummy_d ? dsel : 2'b00;
    end
  end

endmodule

// File: rtl/dps_data.sv
module dps_data #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic              finish,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sa_data,
  output logic [ADDR_W-1:0] row_q,
  output logic              we_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      cap_q   <= '0;
      rd_q    <= '0;
    end else begin
      if (accept) begin
        row_q   <= addr;
        we_q    <= wr;
        wdata_q <= wdata;
      end
      if (capture) cap_q <= sa_data;
      if (finish)  rd_q  <= cap_q;
    end
  end

endmodule

// File: rtl/dram_phase_seq.sv
module dram_phase_seq
  import dps_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned T_GAP  = 1,
  parameter int unsigned T_WORD = 4,
  parameter int unsigned T_SLOW = 3,
  parameter int unsigned T_FAST = 3,
  parameter int unsigned T_EQ   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [DATA_W-1:0]      sa_data,
  output logic                   ack,
  output logic                   busy,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   bl_pre,
  output logic                   dec_pre,
  output logic                   addr_en,
  output logic                   dec_dis,
  output logic                   wl_pulse,
  output logic [(1<<ADDR_W)-1:0] wl,
  output logic [1:0]             dwl,
  output logic                   sense_slow,
  output logic                   sense_fast,
  output logic                   eq,
  output logic                   wr_drv,
  output logic [DATA_W-1:0]      wr_data
);

  localparam int unsigned ROWS = 1 << ADDR_W;

  strobe_t           strb_d, strb_q;
  logic              accept, capture, finish;
  logic [ADDR_W-1:0] row_q;
  logic              we_q;

  dps_fsm #(
    .T_GAP (T_GAP),
    .T_WORD(T_WORD),
    .T_SLOW(T_SLOW),
    .T_FAST(T_FAST),
    .T_EQ  (T_EQ)
  ) i_fsm (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .is_wr  (we_q),
    .strb_d (strb_d),
    .strb_q (strb_q),
    .accept (accept),
    .capture(capture),
    .finish (finish)
  );

  dps_data #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_data (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .capture(capture),
    .finish (finish),
    .addr   (addr),
    .wr     (wr),
    .wdata  (wdata),
    .sa_data(sa_data),
    .row_q  (row_q),
    .we_q   (we_q),
    .wdata_q(wr_data),
    .rd_q   (rd_data)
  );

  dps_row_sel #(
    .ADDR_W(ADDR_W)
  ) i_rows (
    .clk    (clk),
    .rst    (rst),
    .word_d (strb_d.word),
    .dummy_d(strb_d.dummy),
    .row    (row_q),
    .wl     (wl),
    .dwl    (dwl)
  );

  assign bl_pre     = strb_q.bl_pre;
  assign dec_pre    = strb_q.dec_pre;
  assign addr_en    = strb_q.addr_en;
  assign dec_dis    = strb_q.dec_dis;
  assign wl_pulse   = strb_q.word;
  assign sense_slow = strb_q.slow;
  assign sense_fast = strb_q.fast;
  assign eq         = strb_q.eq;
  assign wr_drv     = strb_q.wdrv;
  assign ack        = strb_q.ack;
  assign busy       = strb_q.busy;

endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
  parameter int unsigned ROWS = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            ack,
  input logic            busy,
  input logic            bl_pre,
  input logic            dec_pre,
  input logic            addr_en,
  input logic            dec_dis,
  input logic            wl_pulse,
  input logic [ROWS-1:0] wl,
  input logic [1:0]      dwl,
  input logic            sense_slow,
  input logic            sense_fast,
  input logic            eq,
  input logic            wr_drv
);

  localparam int unsigned HALF = ROWS / 2;

  logic [6:0] grp;
  assign grp = {bl_pre, dec_pre, addr_en, dec_dis, wl_pulse, sense_slow, eq};

  a_r3_pre_excl: assert property (@(posedge clk) disable iff (rst)
    dec_pre |-> !(addr_en || dec_dis || wl_pulse));

  a_r4_one_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wl));

  a_r4_line_gated: assert property (@(posedge clk) disable iff (rst)
    (|wl) |-> (wl_pulse && addr_en && dec_dis));

  a_r5_dummy_upper: assert property (@(posedge clk) disable iff (rst)
    (|wl[HALF-1:0]) |-> (dwl == 2'b10));

  a_r5_dummy_lower: assert property (@(posedge clk) disable iff (rst)
    (|wl[ROWS-1:HALF]) |-> (dwl == 2'b01));

  a_r6_fast_inside_slow: assert property (@(posedge clk) disable iff (rst)
    sense_fast |-> sense_slow);

  a_r6_slow_first: assert property (@(posedge clk) disable iff (rst)
    $rose(sense_fast) |-> $past(sense_slow));

  a_r7_word_drops_first: assert property (@(posedge clk) disable iff (rst)
    $fell(wl_pulse) |-> (sense_slow && sense_fast));

  a_r7_dummy_drops_in_eq: assert property (@(posedge clk) disable iff (rst)
    $fell(|dwl) |-> eq);

  a_r8_ack_ends_busy: assert property (@(posedge clk) disable iff (rst)
    ack |=> !busy);

  a_r9_drive_in_sense: assert property (@(posedge clk) disable iff (rst)
    wr_drv |-> sense_slow);

  a_r12_single_change: assert property (@(posedge clk) disable iff (rst)
    $countones(grp ^ $past(grp)) <= 1);

endmodule

bind dram_phase_seq dps_chk #(.ROWS(ROWS)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .busy      (busy),
  .bl_pre    (bl_pre),
  .dec_pre   (dec_pre),
  .addr_en   (addr_en),
  .dec_dis   (dec_dis),
  .wl_pulse  (wl_pulse),
  .wl        (wl),
  .dwl       (dwl),
  .sense_slow(sense_slow),
  .sense_fast(sense_fast),
  .eq        (eq),
  .wr_drv    (wr_drv)
);

// File: tb/test_dram_phase_seq.sv
module test_dram_phase_seq;

  localparam int AW = 7;
  localparam int DW = 32;
  localparam int ROWS = 1 << AW;
  localparam int G = 1, W = 4, S = 3, F = 3, E = 3;
  localparam int T2 = G, T3 = T2 + G, T4 = T3 + G, T5 = T4 + G;
  localparam int T6 = T5 + W, T7 = T6 + S, T8 = T7 + F, T9 = T8 + G;
  localparam int T10 = T9 + G, T11 = T10 + E, T12 = T11 + G, T13 = T12 + G;
  localparam int T14 = T13 + G, T15 = T14 + G, T16 = T15 + G;

  logic clk, rst, req, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, sa_data, rd_data, wr_data;
  logic ack, busy, bl_pre, dec_pre, addr_en, dec_dis, wl_pulse;
  logic [ROWS-1:0] wl;
  logic [1:0] dwl;
  logic sense_slow, sense_fast, eq, wr_drv;

  int checks = 0;
  int fails = 0;

  dram_phase_seq #(
    .ADDR_W(AW), .DATA_W(DW), .T_GAP(G), .T_WORD(W),
    .T_SLOW(S), .T_FAST(F), .T_EQ(E)
  ) i_dram_phase_seq (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .sa_data(sa_data), .ack(ack), .busy(busy), .rd_data(rd_data),
    .bl_pre(bl_pre), .dec_pre(dec_pre), .addr_en(addr_en), .dec_dis(dec_dis),
    .wl_pulse(wl_pulse), .wl(wl), .dwl(dwl), .sense_slow(sense_slow),
    .sense_fast(sense_fast), .eq(eq), .wr_drv(wr_drv), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Array stand-in: bit lines follow the written word while driven, else the cell.
  logic [DW-1:0] arr [ROWS];
  logic [DW-1:0] exp_mem [ROWS];
  int sa_row;

  always_comb begin
    sa_row = 0;
    for (int r = 0; r < ROWS; r++) if (wl[r]) sa_row = r;
    sa_data = wr_drv ? wr_data : ((|wl) ? arr[sa_row] : '0);
  end

  always @(posedge clk) if (wr_drv && (|wl)) arr[sa_row] <= wr_data;

  task automatic chk(input bit ok, input string tag, input int t,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [DW-1:0] v;
    v = 32'h9E3779B9 * DW'(a + 1 + salt);
    return v ^ DW'(a << 8);
  endfunction

  task automatic access(input int a, input bit w, input logic [DW-1:0] d, input bit hold);
    logic [ROWS-1:0] one;
    logic [ROWS-1:0] wl_exp;
    logic [1:0] dwl_exp;
    logic [DW-1:0] rd_exp;
    logic [6:0] prev, cur;
    bit e;
    one = 1;
    req = 1'b1; wr = w; addr = AW'(a); wdata = d;
    rd_exp = w ? d : exp_mem[a];
    dwl_exp = (a >= ROWS / 2) ? 2'b01 : 2'b10;
    prev = 7'b1100000;
    for (int t = 0; t <= T16; t++) begin
      @(negedge clk);
      if (t == T6) begin
        addr = ~AW'(a); wr = ~w; wdata = ~d;
      end
      e = (t >= T16);
      chk(bl_pre === e, "R2 bl_pre", t, 128'(bl_pre), 128'(e));
      chk(busy === 1'b1, "R2 busy", t, 128'(busy), 128'(1));
      e = (t < T2) || (t >= T15);
      chk(dec_pre === e, "R3 dec_pre", t, 128'(dec_pre), 128'(e));
      e = (t >= T3) && (t < T14);
      chk(addr_en === e, "R3 addr_en", t, 128'(addr_en), 128'(e));
      e = (t >= T4) && (t < T13);
      chk(dec_dis === e, "R3 dec_dis", t, 128'(dec_dis), 128'(e));
      e = (t >= T5) && (t < T8);
      chk(wl_pulse === e, "R4 wl_pulse", t, 128'(wl_pulse), 128'(e));
      wl_exp = e ? (one << a) : '0;
      chk(wl === wl_exp, "R4/R11 wl", t, 128'(wl), 128'(wl_exp));
      e = (t >= T5) && (t < T11);
      chk(dwl === (e ? dwl_exp : 2'b00), "R5 dwl", t, 128'(dwl), 128'(e ? dwl_exp : 2'b00));
      e = (t >= T6) && (t < T9);
      chk(sense_slow === e, "R6 sense_slow", t, 128'(sense_slow), 128'(e));
      chk(wr_drv === (w && e), "R9 wr_drv", t, 128'(wr_drv), 128'(w && e));
      if (w && e) chk(wr_data === d, "R9 wr_data", t, 128'(wr_data), 128'(d));
      e = (t >= T7) && (t < T9);
      chk(sense_fast === e, "R6 sense_fast", t, 128'(sense_fast), 128'(e));
      e = (t >= T10) && (t < T12);
      chk(eq === e, "R7 eq", t, 128'(eq), 128'(e));
      e = (t == T16);
      chk(ack === e, "R8 ack", t, 128'(ack), 128'(e));
      cur = {bl_pre, dec_pre, addr_en, dec_dis, wl_pulse, sense_slow, eq};
      chk($countones(cur ^ prev) <= 1, "R12 one change", t, 128'(cur), 128'(prev));
      prev = cur;
      if (t == T16) begin
        chk(rd_data === rd_exp, "R10 rd_data at ack", t, 128'(rd_data), 128'(rd_exp));
        if (!hold) req = 1'b0;
      end
    end
    if (w) exp_mem[a] = d;
    @(negedge clk);
    chk(busy === 1'b0, "R11 idle clock", T16 + 1, 128'(busy), 128'(0));
    chk(rd_data === rd_exp, "R10 rd_data held", T16 + 1, 128'(rd_data), 128'(rd_exp));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    for (int r = 0; r < ROWS; r++) begin
      arr[r] = '0;
      exp_mem[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk({bl_pre, dec_pre} === 2'b11, "R1 precharges", 0, 128'({bl_pre, dec_pre}), 128'(3));
    chk({addr_en, dec_dis, wl_pulse, sense_slow, sense_fast, eq, wr_drv, ack, busy} === 9'b0,
        "R1 strobes low", 0,
        128'({addr_en, dec_dis, wl_pulse, sense_slow, sense_fast, eq, wr_drv, ack, busy}), 128'(0));
    chk((wl === '0) && (dwl === 2'b00), "R1 lines low", 0, 128'(wl), 128'(0));

    for (int a = 0; a < ROWS; a++) access(a, 1'b1, pat(a, 0), (a % 8) == 7);
    for (int a = ROWS - 1; a >= 0; a--) access(a, 1'b0, '0, (a % 5) == 0);
    access(0, 1'b1, pat(0, 77), 1'b1);
    access(0, 1'b0, '0, 1'b1);
    access(ROWS - 1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    access(ROWS - 1, 1'b0, '0, 1'b0);
    access(ROWS / 2, 1'b0, '0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule